// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block steps a single DMA channel through its two nested loop levels. A start, either a software strobe or a hardware request that is currently enabled, runs one inner loop. The inner loop is a train of read/write access pairs. Each pair moves one beat of 1, 2, 4 or 8 bytes and takes that beat off the programmed byte count. When the byte count runs out, the outer iteration counter drops by one. When the outer counter runs out, it is refilled from its starting value and the done flag is set. At the end of each inner loop the block can also raise an interrupt pulse, emit a link trigger for another channel and clear its own hardware-request enable.

Between accesses the sequencer can insert programmable idle cycles to hold down its bus bandwidth. In continuous mode, a channel whose per-inner-loop link names itself restarts at once without waiting for a new request. An access error abandons the inner loop in progress. Address generation and channel arbitration are done elsewhere.

The state machine has six states. IDLE waits for a start. READ holds the read strobe. RSTALL is the idle gap after a read. WRITE holds the write strobe. WSTALL is the idle gap after a write. FINISH is a single cycle that closes an inner loop. The transitions are:
- start (IDLE to READ);
- read_ack (READ to RSTALL, or to WRITE when there is no gap);
- rgap_end (RSTALL to WRITE);
- write_ack (WRITE to WSTALL, READ or FINISH);
- wgap_end (WSTALL to READ or FINISH);
- abort (READ or WRITE to IDLE);
- close (FINISH to IDLE);
- self_restart (FINISH to READ).

Top module: `dma_loop_seq`

## Requirements
- R1: After reset the block is idle. Read and write strobes, done, error, interrupt, link pulse, hardware-request enable and the iteration counter are all 0.
- R2: An inner loop alternates one read and one write per beat. The beat is 2^beat_size bytes. The loop ends when the remaining count reaches zero, and a final partial beat counts as a whole beat. While busy, nbytes_left shows the remaining byte count; while idle it shows nbytes.
- R3: A start is sw_start, or hw_req while req_en is 1. A start is ignored while the iteration counter is 0. desc_load copies biter into the counter and clears done and err_flag.
- R4: Closing an inner loop that is not the last one lowers the iteration counter by exactly 1.
- R5: Closing the inner loop that brings the counter to zero instead reloads it from biter and sets done.
- R6: One cycle after FINISH, irq pulses for one cycle if either of these holds: int_major_en is set and the count ran out, or int_half_en is set and the decremented count equals biter shifted right by one. If both hold, there is still only one pulse. With both enables clear, irq never pulses.
- R7: link_mode selects the link trigger. With 1, link_pulse fires after every inner loop. With 2, it fires only when the count runs out. With 0, it never fires. link_ch_out always carries link_ch.
- R8: bw_code sets the idle cycles inserted after every read and every write. Code 2 gives 4 cycles, code 3 gives 8, and codes 0 and 1 give none.
- R9: With auto_stop set, the run-out of the count clears req_en, after which hw_req starts nothing. req_en_set sets req_en.
- R10: With cont_link set, link_mode 1 and link_ch equal to the channel's own number, every inner loop except the one that runs out the count restarts at once.
- R11: err_in during READ or WRITE returns the block to IDLE and sets err_flag. The iteration counter and done are left unchanged.
- R12: Read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load biter into the counter, clear done and error |
| nbytes | input | NB_W | Bytes per inner loop |
| beat_size | input | 2 | Beat size code, beat = 2^code bytes |
| biter | input | IT_W | Starting iteration count |
| int_major_en | input | 1 | Interrupt on count run-out |
| int_half_en | input | 1 | Interrupt at half count |
| link_mode | input | 2 | 0 none, 1 every inner loop, 2 on run-out |
| link_ch | input | CH_W | Channel to trigger |
| bw_code | input | 2 | Idle-gap code |
| auto_stop | input | 1 | Clear req_en on run-out |
| cont_link | input | 1 | Continuous self-restart enable |
| req_en_set | input | 1 | Set the hardware-request enable |
| hw_req | input | 1 | Hardware service request |
| sw_start | input | 1 | Software start strobe |
| rd_done | input | 1 | Read access finished |
| wr_done | input | 1 | Write access finished |
| err_in | input | 1 | Access error |
| rd_req | output | 1 | Read strobe |
| wr_req | output | 1 | Write strobe |
| busy | output | 1 | Not in IDLE |
| nbytes_left | output | NB_W | Remaining bytes while busy, nbytes while idle |
| citer | output | IT_W | Current iteration count |
| done | output | 1 | Count has run out |
| err_flag | output | 1 | Inner loop aborted by error |
| irq | output | 1 | Interrupt pulse |
| link_pulse | output | 1 | Link trigger pulse |
| link_ch_out | output | CH_W | Channel to trigger |
| req_en | output | 1 | Hardware-request enable |

## Verification
The hardest state to reach is an abort in the middle of a loop. Reaching it takes a partly consumed byte count and a pending access at the same moment. The stimulus turns off the automatic access responder and acknowledges one read and one write by hand. It then checks the decremented remaining count on the second read and raises err_in while that read is still pending. Continuous self-restart is reached from a single start strobe and must run until the count runs out. The auto-stop case holds hw_req high across the run-out, so any missed clear of req_en would show up as extra reads.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RSTALL,
        ST_WRITE,
        ST_WSTALL,
        ST_FINISH
    } seq_state_t;

    localparam logic [1:0] LINK_EVERY = 2'd1;
    localparam logic [1:0] LINK_RUNOUT = 2'd2;

    // Idle cycles inserted after each access for a bandwidth code.
    function automatic int unsigned stall_len(input logic [1:0] code,
                                              input int unsigned n_short,
                                              input int unsigned n_long);
        unique case (code)
            2'd2:    return n_short;
            2'd3:    return n_long;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dma_stall_timer.sv
module dma_stall_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dma_iter_ctrl.sv
module dma_iter_ctrl #(
    parameter int IT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [IT_W-1:0] biter,
    input  logic            minor_end,
    input  logic            int_major_en,
    input  logic            int_half_en,
    input  logic [1:0]      link_mode,
    output logic [IT_W-1:0] citer,
    output logic            done,
    output logic            major_end,
    output logic            irq,
    output logic            link_pulse
);
    import dma_seq_pkg::*;

    logic [IT_W-1:0] cnt_q;
    logic [IT_W-1:0] cnt_dec;
    logic            half_hit;

    assign cnt_dec   = cnt_q - IT_W'(1);
    assign major_end = minor_end && (cnt_q == IT_W'(1));
    assign half_hit  = (cnt_dec == (biter >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            done       <= 1'b0;
            irq        <= 1'b0;
            link_pulse <= 1'b0;
        end else begin
            irq        <= minor_end && ((major_end && int_major_en) || (half_hit && int_half_en));
            link_pulse <= minor_end && ((link_mode == LINK_EVERY) ||
                                        ((link_mode == LINK_RUNOUT) && major_end));
            if (load) begin
                cnt_q <= biter;
                done  <= 1'b0;
            end else if (major_end) begin
                cnt_q <= biter;
                done  <= 1'b1;
            end else if (minor_end) begin
                cnt_q <= cnt_dec;
            end
        end
    end

    assign citer = cnt_q;

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_end && !major_end && !load) |=> (citer == $past(citer) - IT_W'(1)));

    a_r5_reload_done: assert property (@(posedge clk) disable iff (!rst_n)
        (major_end && !load) |=> (done && citer == $past(biter)));

    a_r6_irq_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(minor_end));

    a_r7_link_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        link_pulse |-> $past(minor_end));
endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq #(
    parameter int CH_W        = 4,
    parameter int CH_ID       = 2,
    parameter int NB_W        = 16,
    parameter int IT_W        = 12,
    parameter int STALL_SHORT = 4,
    parameter int STALL_LONG  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            desc_load,
    input  logic [NB_W-1:0] nbytes,
    input  logic [1:0]      beat_size,
    input  logic [IT_W-1:0] biter,
    input  logic            int_major_en,
    input  logic            int_half_en,
    input  logic [1:0]      link_mode,
    input  logic [CH_W-1:0] link_ch,
    input  logic [1:0]      bw_code,
    input  logic            auto_stop,
    input  logic            cont_link,
    input  logic            req_en_set,
    input  logic            hw_req,
    input  logic            sw_start,
    input  logic            rd_done,
    input  logic            wr_done,
    input  logic            err_in,
    output logic            rd_req,
    output logic            wr_req,
    output logic            busy,
    output logic [NB_W-1:0] nbytes_left,
    output logic [IT_W-1:0] citer,
    output logic            done,
    output logic            err_flag,
    output logic            irq,
    output logic            link_pulse,
    output logic [CH_W-1:0] link_ch_out,
    output logic            req_en
);
    import dma_seq_pkg::*;

    localparam int STALL_W = $clog2(STALL_LONG + 1);

    seq_state_t         state_q, state_d;
    logic [NB_W-1:0]    rem_q;
    logic [NB_W-1:0]    beat_bytes;
    logic [STALL_W-1:0] stall_n;
    logic               stall_on;
    logic               gap_over;
    logic               gap_load;
    logic               start_ok;
    logic               last_beat;
    logic               minor_end;
    logic               major_end;
    logic               self_restart;
    logic               abort;
    logic               req_en_q;
    logic               err_q;

    assign beat_bytes   = NB_W'(1) << beat_size;
    assign stall_n      = STALL_W'(stall_len(bw_code, STALL_SHORT, STALL_LONG));
    assign stall_on     = (stall_n != '0);
    assign start_ok     = (sw_start || (hw_req && req_en_q)) && (citer != '0);
    assign last_beat    = (rem_q <= beat_bytes);
    assign minor_end    = (state_q == ST_FINISH);
    assign self_restart = cont_link && (link_mode == LINK_EVERY) &&
                          (link_ch == CH_W'(CH_ID)) && !major_end;
    assign abort        = err_in && ((state_q == ST_READ) || (state_q == ST_WRITE));
    assign gap_load     = stall_on && !err_in &&
                          (((state_q == ST_READ) && rd_done) || ((state_q == ST_WRITE) && wr_done));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_READ;
            ST_READ: begin
                if (err_in)       state_d = ST_IDLE;
                else if (rd_done) state_d = stall_on ? ST_RSTALL : ST_WRITE;
            end
            ST_RSTALL: if (gap_over) state_d = ST_WRITE;
            ST_WRITE: begin
                if (err_in)         state_d = ST_IDLE;
                else if (wr_done) begin
                    if (stall_on)       state_d = ST_WSTALL;
                    else if (last_beat) state_d = ST_FINISH;
                    else                state_d = ST_READ;
                end
            end
            ST_WSTALL: if (gap_over) state_d = (rem_q == '0) ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = self_restart ? ST_READ : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            req_en_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (((state_q == ST_IDLE) && start_ok) || (minor_end && self_restart)) begin
                rem_q <= nbytes;
            end else if ((state_q == ST_WRITE) && wr_done && !err_in) begin
                rem_q <= last_beat ? '0 : rem_q - beat_bytes;
            end
            if (minor_end && major_end && auto_stop) req_en_q <= 1'b0;
            else if (req_en_set)                     req_en_q <= 1'b1;
            if (desc_load)  err_q <= 1'b0;
            else if (abort) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rd_req      = (state_q == ST_READ);
        wr_req      = (state_q == ST_WRITE);
        busy        = (state_q != ST_IDLE);
        nbytes_left = busy ? rem_q : nbytes;
        err_flag    = err_q;
        req_en      = req_en_q;
        link_ch_out = link_ch;
    end

    dma_stall_timer #(.CNT_W(STALL_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .len     (stall_n),
        .expired (gap_over)
    );

    dma_iter_ctrl #(.IT_W(IT_W)) u_iter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (desc_load),
        .biter        (biter),
        .minor_end    (minor_end),
        .int_major_en (int_major_en),
        .int_half_en  (int_half_en),
        .link_mode    (link_mode),
        .citer        (citer),
        .done         (done),
        .major_end    (major_end),
        .irq          (irq),
        .link_pulse   (link_pulse)
    );

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req}));

    a_r2_bytes_spent: assert property (@(posedge clk) disable iff (!rst_n)
        minor_end |-> (rem_q == '0));

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !desc_load) |=> (!busy && err_flag));

    a_r9_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_end && major_end && auto_stop) |=> !req_en);

    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_end && self_restart) |=> rd_req);

    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_req) && stall_on && !$past(err_in) |-> !wr_req);
endmodule

// File: tb/dma_loop_seq_bench.sv
module dma_loop_seq_bench;
    localparam int CH_W = 4;
    localparam int CH_ID = 2;
    localparam int NB_W = 16;
    localparam int IT_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_load = 0, int_major_en = 0, int_half_en = 0, auto_stop = 0, cont_link = 0;
    logic req_en_set = 0, hw_req = 0, sw_start = 0, err_in = 0;
    logic [NB_W-1:0] nbytes = '0;
    logic [1:0] beat_size = 0, link_mode = 0, bw_code = 0;
    logic [IT_W-1:0] biter = '0;
    logic [CH_W-1:0] link_ch = '0;
    logic resp_en = 1, rd_auto = 0, wr_auto = 0, man_rd = 0, man_wr = 0;
    logic rd_done, wr_done;
    logic rd_req, wr_req, busy, done, err_flag, irq, link_pulse, req_en;
    logic [NB_W-1:0] nbytes_left;
    logic [IT_W-1:0] citer;
    logic [CH_W-1:0] link_ch_out;

    int n_checks = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_irq = 0, n_link = 0, n_gap = 0;
    int b_rd, b_wr, b_irq, b_link, b_gap;
    bit finished = 0;

    assign rd_done = rd_auto | man_rd;
    assign wr_done = wr_auto | man_wr;

    always #10 clk = ~clk;

    dma_loop_seq #(.CH_W(CH_W), .CH_ID(CH_ID), .NB_W(NB_W), .IT_W(IT_W)) u_dma_loop_seq (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .nbytes(nbytes), .beat_size(beat_size),
        .biter(biter), .int_major_en(int_major_en), .int_half_en(int_half_en), .link_mode(link_mode),
        .link_ch(link_ch), .bw_code(bw_code), .auto_stop(auto_stop), .cont_link(cont_link),
        .req_en_set(req_en_set), .hw_req(hw_req), .sw_start(sw_start), .rd_done(rd_done),
        .wr_done(wr_done), .err_in(err_in), .rd_req(rd_req), .wr_req(wr_req), .busy(busy),
        .nbytes_left(nbytes_left), .citer(citer), .done(done), .err_flag(err_flag), .irq(irq),
        .link_pulse(link_pulse), .link_ch_out(link_ch_out), .req_en(req_en)
    );

    // Event counting and automatic access responder
    always @(negedge clk) begin
        if (rd_done) n_rd++;
        if (wr_done) n_wr++;
        if (irq) n_irq++;
        if (link_pulse) n_link++;
        if (busy && !rd_req && !wr_req) n_gap++;
        rd_auto = resp_en && rd_req;
        wr_auto = resp_en && wr_req;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic snap();
        b_rd = n_rd; b_wr = n_wr; b_irq = n_irq; b_link = n_link; b_gap = n_gap;
    endtask

    task automatic set_desc(input int nb, input int sz, input int bi, input int bw, input int lm,
                            input int lc, input bit ints, input bit as, input bit cl);
        nbytes = NB_W'(nb); beat_size = 2'(sz); biter = IT_W'(bi); bw_code = 2'(bw);
        link_mode = 2'(lm); link_ch = CH_W'(lc); int_major_en = ints; int_half_en = ints;
        auto_stop = as; cont_link = cl;
        desc_load = 1; cyc(1); desc_load = 0; cyc(1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000; k++) begin
            if (!busy) break;
            cyc(1);
        end
        cyc(2);
    endtask

    task automatic pulse_start();
        sw_start = 1; cyc(1); sw_start = 0; cyc(1);
        wait_idle();
    endtask

    typedef struct packed {
        logic [15:0] nb; logic [1:0] sz; logic [11:0] bi; logic [1:0] bw; logic [1:0] lm;
        logic [3:0] runs; logic [7:0] e_rd; logic [7:0] e_gap; logic [3:0] e_irq;
        logic [3:0] e_link; logic [11:0] e_citer; logic e_done;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{16'd8,  2'd0, 12'd4, 2'd0, 2'd0, 4'd1, 8'd8, 8'd1,  4'd0, 4'd0, 12'd3, 1'b0},
        '{16'd8,  2'd2, 12'd4, 2'd2, 2'd1, 4'd2, 8'd4, 8'd34, 4'd1, 4'd2, 12'd2, 1'b0},
        '{16'd16, 2'd3, 12'd2, 2'd3, 2'd2, 4'd2, 8'd4, 8'd66, 4'd2, 4'd1, 12'd2, 1'b1},
        '{16'd6,  2'd2, 12'd3, 2'd1, 2'd2, 4'd3, 8'd6, 8'd3,  4'd2, 4'd1, 12'd3, 1'b1},
        '{16'd3,  2'd1, 12'd1, 2'd0, 2'd1, 4'd1, 8'd2, 8'd1,  4'd1, 4'd1, 12'd1, 1'b1}
    };

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check(!busy && !rd_req && !wr_req, "R1 idle strobes", {busy, rd_req, wr_req}, 0);
        check(!done && !err_flag && !irq && !link_pulse && !req_en, "R1 flags",
              {done, err_flag, irq, link_pulse, req_en}, 0);
        check(citer == 0, "R1 citer", citer, 0);

        // R3 start ignored with zero count
        snap();
        sw_start = 1; cyc(1); sw_start = 0; cyc(2);
        check(!busy && n_rd == b_rd, "R3 start with zero count", n_rd - b_rd, 0);

        // Table of loop configurations (R2 R4 R5 R6 R7 R8)
        for (int i = 0; i < 5; i++) begin
            set_desc(int'(VECS[i].nb), int'(VECS[i].sz), int'(VECS[i].bi), int'(VECS[i].bw),
                     int'(VECS[i].lm), 1, 1'b1, 1'b0, 1'b0);
            check(nbytes_left == VECS[i].nb, "R2 idle byte count", int'(nbytes_left), int'(VECS[i].nb));
            snap();
            for (int r = 0; r < int'(VECS[i].runs); r++) pulse_start();
            check(n_rd - b_rd == int'(VECS[i].e_rd), "R2 reads", n_rd - b_rd, int'(VECS[i].e_rd));
            check(n_wr - b_wr == int'(VECS[i].e_rd), "R2 writes", n_wr - b_wr, int'(VECS[i].e_rd));
            check(n_gap - b_gap == int'(VECS[i].e_gap), "R8 idle gaps", n_gap - b_gap, int'(VECS[i].e_gap));
            check(citer == VECS[i].e_citer, "R4 R5 citer", int'(citer), int'(VECS[i].e_citer));
            check(done == VECS[i].e_done, "R5 done", done, VECS[i].e_done);
            check(n_irq - b_irq == int'(VECS[i].e_irq), "R6 irq", n_irq - b_irq, int'(VECS[i].e_irq));
            check(n_link - b_link == int'(VECS[i].e_link), "R7 link", n_link - b_link, int'(VECS[i].e_link));
        end
        check(link_ch_out == 1, "R7 link channel", int'(link_ch_out), 1);

        // R3 desc_load clears done
        set_desc(3, 1, 1, 0, 0, 1, 1'b0, 1'b0, 1'b0);
        check(!done && citer == 1, "R3 load clears done", {done, citer}, 1);

        // R6 enables off: run-out without interrupt
        snap();
        pulse_start();
        check(done && n_irq == b_irq, "R6 interrupts disabled", n_irq - b_irq, 0);

        // R9 hardware request, enable and auto-stop
        set_desc(1, 0, 2, 0, 0, 1, 1'b0, 1'b1, 1'b0);
        snap();
        hw_req = 1; cyc(4);
        check(!busy && n_rd == b_rd, "R9 request without enable", n_rd - b_rd, 0);
        req_en_set = 1; cyc(1); req_en_set = 0;
        cyc(30);
        check(n_rd - b_rd == 2, "R9 loops before auto-stop", n_rd - b_rd, 2);
        check(!req_en && done, "R9 enable cleared", req_en, 0);
        hw_req = 0; cyc(2);

        // R10 continuous self restart
        set_desc(2, 0, 3, 0, 1, CH_ID, 1'b1, 1'b0, 1'b1);
        snap();
        pulse_start();
        check(n_rd - b_rd == 6, "R10 self restart reads", n_rd - b_rd, 6);
        check(n_link - b_link == 3 && done && citer == 3, "R10 self restart links", n_link - b_link, 3);

        // R11 abort mid-loop
        set_desc(4, 0, 5, 0, 0, 1, 1'b0, 1'b0, 1'b0);
        resp_en = 0;
        sw_start = 1; cyc(1); sw_start = 0;
        for (int k = 0; k < 20 && !rd_req; k++) cyc(1);
        check(nbytes_left == 4, "R2 count at first read", int'(nbytes_left), 4);
        man_rd = 1; cyc(1); man_rd = 0;
        for (int k = 0; k < 20 && !wr_req; k++) cyc(1);
        man_wr = 1; cyc(1); man_wr = 0;
        for (int k = 0; k < 20 && !rd_req; k++) cyc(1);
        check(nbytes_left == 3, "R2 count decrements", int'(nbytes_left), 3);
        err_in = 1; cyc(1); err_in = 0; cyc(1);
        check(!busy && err_flag, "R11 abort", {busy, err_flag}, 1);
        check(citer == 5 && !done, "R11 count kept", int'(citer), 5);
        resp_en = 1;
        set_desc(4, 0, 5, 0, 0, 1, 1'b0, 1'b0, 1'b0);
        check(!err_flag, "R3 load clears error", err_flag, 0);

        // R12 strobes exclusive (sampled across one more run)
        snap();
        sw_start = 1; cyc(1); sw_start = 0;
        for (int k = 0; k < 20; k++) begin
            check(!(rd_req && wr_req), "R12 exclusive strobes", {rd_req, wr_req}, 0);
            cyc(1);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule